// File: doc/BRIEF.md
# Timer Event, Alarm and Trigger Capture Unit

This unit sits beside a free-running 64-bit time counter and turns its value into timing events. Two alarm comparators each hold a programmed 64-bit time and fire once when the counter reaches that time. Each firing drives a one-cycle pulse on an alarm pin whose active level can be programmed. Two asynchronous trigger pins are synchronised. On the edge chosen for each pin, the unit copies the current time into a capture register.

Every alarm firing and every capture sets a bit in an event register. Software acknowledges an event by writing a one to its bit. A mask register uses the same bit positions as the event register and decides which pending events reach the single interrupt line. Software reaches all state through a simple word-addressed register bus. Writes take effect on the clock edge. Reads are combinational from the address. For a periodic alarm, software re-arms the alarm from its event handler.

Top module: `tmr_event_unit`

## Requirements
- R1: After synchronous active-low reset, the control, event, mask and capture registers read zero, alarms are disarmed, `irq` is low and both alarm pins are low.
- R2: While an alarm is armed and `cur_time` equals its stored time at a clock edge, that edge sets the alarm's event bit: bit 16 for alarm 0, bit 17 for alarm 1. The alarm pin is active for exactly one cycle after that edge.
- R3: An alarm is written as a low word (address 3 or 5) followed by a high word (address 4 or 6). Only the high-word write arms it. An alarm fires once per arming and then stays disarmed, even if `cur_time` matches again.
- R4: Control bit 31 (alarm 0) and bit 30 (alarm 1) select the pin polarity. When the bit is 0 the pin idles low and pulses high. When the bit is 1 the pin idles high and pulses low.
- R5: Each trigger passes through two synchroniser flops and an edge detector. Control bit 8 (trigger 0) and bit 9 (trigger 1) select the edge: 0 means rising and 1 means falling. A pin change before edge k is captured at edge k+2 with the `cur_time` of that edge, and the capture sets event bit 24 or 25. An edge of the other polarity has no effect.
- R6: Capture registers are read as a high word and a low word (trigger 0 at 7/8, trigger 1 at 9/10). A new edge overwrites the capture even while its event is still pending.
- R7: A write to the event register (address 1) clears every bit written as one and leaves bits written as zero unchanged. A new event arriving at the same edge as its clear wins.
- R8: The mask register (address 2) uses the event bit positions, and `irq` is high exactly when some event bit and its mask bit are both set.
- R9: Only event and mask bits 16, 17, 24 and 25 and control bits 31, 30, 9 and 8 are stored. All other bits, and unmapped addresses, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 64 | Current time from the counter |
| trig_in | input | 2 | Asynchronous trigger pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| alarm_pin | output | 2 | Alarm output pins |
| irq | output | 1 | Masked event interrupt |

## Verification
A lost or stuck arm flag shows at the alarm pin and `irq` in the cycle after the intended match: either the pulse is missing, or a second pulse appears when time is forced back onto the alarm value. A synchroniser or edge-select fault shifts the captured time by a multiple of the counter step, or captures the wrong polarity. A read of the capture words exposes this after about three cycles. The bench compares pins and interrupt against a behavioural model on every cycle, so a wrong event or mask bit shows on `irq` in the same cycle.

// File: rtl/tmr_evt_pkg.sv
// Shared constants for the timer event unit: register addresses and bit
// positions. Assumes a 32-bit register bus and two alarms plus two triggers.
package tmr_evt_pkg;
    localparam int unsigned N_ALARM  = 2;
    localparam int unsigned N_TRIG   = 2;
    localparam int unsigned BUS_W    = 32;
    localparam int unsigned ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVT    = 4'd1;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd2;
    localparam logic [ADDR_W-1:0] A_AL_LO0 = 4'd3;  // alarm i low  = 3 + 2i
    localparam logic [ADDR_W-1:0] A_CP_HI0 = 4'd7;  // capture i high = 7 + 2i

    localparam int unsigned B_ALM0   = 16;  // alarm event bits 16, 17
    localparam int unsigned B_TRG0   = 24;  // trigger event bits 24, 25
    localparam int unsigned B_POL0   = 31;  // polarity bits 31, 30
    localparam int unsigned B_EDG0   = 8;   // edge bits 8, 9

    localparam logic [BUS_W-1:0] EVT_IMPL = 32'h0303_0000;
endpackage

// File: rtl/tmr_alarm_cmp.sv
// One alarm comparator. Holds a staged low word and a full alarm time; a
// high-word write loads the time and arms it. Fires once per arming when the
// current time equals the alarm time, then drives a one-cycle pin pulse.
// Assumes TIME_W is larger than 32 and at most 64.
module tmr_alarm_cmp #(
    parameter int unsigned TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    input  logic              polarity,
    output logic              fire,
    output logic              armed,
    output logic              pin
);
    localparam int unsigned HI_W = TIME_W - 32;

    logic [31:0]       lo_stage_q;
    logic [TIME_W-1:0] alarm_q;
    logic              pulse_q;

    // Compare only while armed.
    always_comb begin
        fire = armed && (cur_time == alarm_q);
    end

    // Stage the low word, load and arm on high word, disarm after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage_q <= '0;
            alarm_q    <= '0;
            armed      <= 1'b0;
            pulse_q    <= 1'b0;
        end else begin
            if (wr_lo) lo_stage_q <= wdata;
            if (wr_hi) begin
                alarm_q <= {wdata[HI_W-1:0], lo_stage_q};
                armed   <= 1'b1;
            end else if (fire) begin
                armed   <= 1'b0;
            end
            pulse_q <= fire;
        end
    end

    // Apply programmed polarity to the pulse.
    always_comb begin
        pin = pulse_q ^ polarity;
    end
endmodule

// File: rtl/tmr_trig_cap.sv
// One external trigger capture. The pin passes through SYNC_N flops, an
// edge detector picks rising or falling, and the detected edge copies the
// current time into the capture register. Assumes SYNC_N >= 2.
module tmr_trig_cap #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              fall_sel,
    input  logic [TIME_W-1:0] cur_time,
    output logic              hit,
    output logic [TIME_W-1:0] cap
);
    logic [SYNC_N-1:0] sync_q;
    logic              last_q;

    // Detect the selected edge on the synchronised level.
    always_comb begin
        if (fall_sel) hit = !sync_q[SYNC_N-1] &&  last_q;
        else          hit =  sync_q[SYNC_N-1] && !last_q;
    end

    // Synchronise, remember previous level, capture time on edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
            cap    <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], trig_in};
            last_q <= sync_q[SYNC_N-1];
            if (hit) cap <= cur_time;
        end
    end
endmodule

// File: rtl/tmr_event_unit.sv
// Timer event unit top. Holds control, event and mask registers, instances
// the alarm comparators and trigger captures, and drives the masked
// interrupt. Register writes take effect at the clock edge; reads are
// combinational from the address. Assumes TIME_W between 33 and 64.
module tmr_event_unit
    import tmr_evt_pkg::*;
#(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic [N_ALARM-1:0] alarm_pin,
    output logic              irq
);
    logic [N_ALARM-1:0] pol_q;
    logic [N_TRIG-1:0]  edg_q;
    logic [BUS_W-1:0]   evt_q;
    logic [BUS_W-1:0]   mask_q;
    logic [BUS_W-1:0]   set_vec;
    logic [BUS_W-1:0]   clr_vec;
    logic [N_ALARM-1:0] fire_w;
    logic [N_ALARM-1:0] armed_w;
    logic [N_TRIG-1:0]  hit_w;
    logic [TIME_W-1:0]  cap_w [N_TRIG];

    logic wr_ctrl, wr_evt, wr_mask;
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_evt  = reg_wr && (reg_addr == A_EVT);
    assign wr_mask = reg_wr && (reg_addr == A_MASK);

    // Alarm comparators, one per alarm.
    for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
        localparam logic [ADDR_W-1:0] LO_A = A_AL_LO0 + ADDR_W'(2 * i);
        tmr_alarm_cmp #(.TIME_W(TIME_W)) alarm_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_time (cur_time),
            .wr_lo    (reg_wr && (reg_addr == LO_A)),
            .wr_hi    (reg_wr && (reg_addr == LO_A + 4'd1)),
            .wdata    (reg_wdata),
            .polarity (pol_q[i]),
            .fire     (fire_w[i]),
            .armed    (armed_w[i]),
            .pin      (alarm_pin[i])
        );
    end

    // Trigger captures, one per trigger pin.
    for (genvar i = 0; i < N_TRIG; i++) begin : g_trig
        tmr_trig_cap #(.TIME_W(TIME_W), .SYNC_N(SYNC_N)) trig_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_in  (trig_in[i]),
            .fall_sel (edg_q[i]),
            .cur_time (cur_time),
            .hit      (hit_w[i]),
            .cap      (cap_w[i])
        );
    end

    // Gather event sources and write-one clear requests.
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < N_ALARM; i++) set_vec[B_ALM0 + i] = fire_w[i];
        for (int i = 0; i < N_TRIG; i++)  set_vec[B_TRG0 + i] = hit_w[i];
        clr_vec = wr_evt ? reg_wdata : '0;
    end

    // Control, event and mask registers; a new event beats its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edg_q  <= '0;
            evt_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) begin
                for (int i = 0; i < N_ALARM; i++) pol_q[i] <= reg_wdata[B_POL0 - i];
                for (int i = 0; i < N_TRIG; i++)  edg_q[i] <= reg_wdata[B_EDG0 + i];
            end
            if (wr_mask) mask_q <= reg_wdata & EVT_IMPL;
            evt_q <= ((evt_q & ~clr_vec) | set_vec) & EVT_IMPL;
        end
    end

    // Masked interrupt.
    always_comb begin
        irq = |(evt_q & mask_q);
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            for (int i = 0; i < N_ALARM; i++) reg_rdata[B_POL0 - i] = pol_q[i];
            for (int i = 0; i < N_TRIG; i++)  reg_rdata[B_EDG0 + i] = edg_q[i];
        end else if (reg_addr == A_EVT) begin
            reg_rdata = evt_q;
        end else if (reg_addr == A_MASK) begin
            reg_rdata = mask_q;
        end else begin
            for (int i = 0; i < N_TRIG; i++) begin
                if (reg_addr == A_CP_HI0 + ADDR_W'(2 * i))
                    reg_rdata = BUS_W'(cap_w[i] >> 32);
                if (reg_addr == A_CP_HI0 + ADDR_W'(2 * i + 1))
                    reg_rdata = cap_w[i][31:0];
            end
        end
    end
endmodule

// File: rtl/tmr_event_unit_chk.sv
// Checker for the timer event unit, bound to the top. Watches pins, the
// interrupt and internal event, mask, arm and capture state.
module tmr_event_unit_chk
    import tmr_evt_pkg::*;
#(
    parameter int unsigned TIME_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic [N_ALARM-1:0] alarm_pin,
    input logic [N_ALARM-1:0] pol_q,
    input logic [N_ALARM-1:0] armed,
    input logic [BUS_W-1:0]   evt_q,
    input logic [BUS_W-1:0]   mask_q,
    input logic [TIME_W-1:0]  cap0,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [BUS_W-1:0]   reg_wdata
);
    logic act0;
    assign act0 = alarm_pin[0] ^ pol_q[0];

    // R2: an active alarm pulse coincides with its event bit being set.
    assert_pulse_sets_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act0 |-> evt_q[B_ALM0]);

    // R3: after firing, the alarm is disarmed unless re-armed at that edge.
    assert_fire_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act0 && !$past(reg_wr && reg_addr == 4'd4) |-> !armed[0]);

    // R6: the capture register only changes together with its event.
    assert_cap_sets_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap0) |-> evt_q[B_TRG0]);

    // R7: writing zero to a pending event bit leaves it set.
    assert_zero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_addr == A_EVT && !reg_wdata[B_TRG0]) && $past(evt_q[B_TRG0])
        |-> evt_q[B_TRG0]);

    // R8: with everything masked the interrupt stays low.
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == '0 |-> !irq);
endmodule

bind tmr_event_unit tmr_event_unit_chk #(.TIME_W(TIME_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .alarm_pin (alarm_pin),
    .pol_q     (pol_q),
    .armed     (armed_w),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .cap0      (cap_w[0]),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/tmr_event_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_event_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cur_time = 64'd1000;
    logic [1:0]  trig_in = 2'b00;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [1:0]  alarm_pin;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int act_cnt0 = 0;

    always #2.5 clk = ~clk;

    tmr_event_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .trig_in(trig_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_pin(alarm_pin), .irq(irq)
    );

    // Behavioural model state.
    logic [31:0] m_evt, m_mask;
    logic [1:0]  m_pol, m_edg, m_arm, m_pulse;
    logic [63:0] m_alm [2];
    logic [31:0] m_lo [2];
    logic [63:0] m_cap [2];
    logic [2:0]  m_sh [2];  // [0] first flop, [1] second, [2] previous level

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model update at each edge, then per-cycle comparison of pins and irq.
    always @(posedge clk) begin
        logic [1:0] f, h;
        cyc++;
        if (!rst_n) begin
            m_evt = 0; m_mask = 0; m_pol = 0; m_edg = 0; m_arm = 0; m_pulse = 0;
            for (int i = 0; i < 2; i++) begin
                m_alm[i] = 0; m_lo[i] = 0; m_cap[i] = 0; m_sh[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                f[i] = m_arm[i] && (cur_time == m_alm[i]);
                h[i] = m_edg[i] ? (!m_sh[i][1] && m_sh[i][2]) : (m_sh[i][1] && !m_sh[i][2]);
            end
            if (reg_wr && reg_addr == 4'd1) m_evt = m_evt & ~reg_wdata;
            for (int i = 0; i < 2; i++) begin
                if (f[i]) m_evt[16 + i] = 1'b1;
                if (h[i]) begin m_evt[24 + i] = 1'b1; m_cap[i] = cur_time; end
                if (reg_wr && reg_addr == 4'(3 + 2 * i)) m_lo[i] = reg_wdata;
                if (reg_wr && reg_addr == 4'(4 + 2 * i)) begin
                    m_alm[i] = {reg_wdata, m_lo[i]};
                    m_arm[i] = 1'b1;
                end else if (f[i]) m_arm[i] = 1'b0;
                m_pulse[i] = f[i];
                m_sh[i] = {m_sh[i][1], m_sh[i][0], trig_in[i]};
            end
            if (reg_wr && reg_addr == 4'd2) m_mask = reg_wdata & 32'h0303_0000;
            if (reg_wr && reg_addr == 4'd0) begin
                m_pol = {reg_wdata[30], reg_wdata[31]};
                m_edg = reg_wdata[9:8];
            end
        end
        #1;
        check("R2/R4 alarm pins", 64'(alarm_pin), 64'(m_pulse ^ m_pol));
        check("R8 irq", 64'(irq), 64'(|(m_evt & m_mask)));
        if (alarm_pin[0] != m_pol[0]) act_cnt0++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        cur_time = cur_time + 64'd8;
        reg_wr = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        tick();
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
        tick();
        reg_addr = a;
        #1;
        check(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        logic [63:0] tgt, tk;
        ticks(4);
        rst_n = 1'b1;
        ticks(1);
        // R1: reset state
        rd("R1 ctrl", 4'd0, 32'h0);
        rd("R1 event", 4'd1, 32'h0);
        rd("R1 mask", 4'd2, 32'h0);
        rd("R1 capture", 4'd8, 32'h0);
        check("R1 irq/pins", 64'({irq, alarm_pin}), 64'd0);

        // R9: unimplemented bits and addresses read zero
        wr(4'd2, 32'hFFFF_FFFF);
        rd("R9 mask bits", 4'd2, 32'h0303_0000);
        rd("R9 unmapped", 4'd15, 32'h0);

        // R2: alarm 0 fires at its time
        act_cnt0 = 0;
        tgt = cur_time + 64'd80;
        wr(4'd3, tgt[31:0]);
        wr(4'd4, tgt[63:32]);
        ticks(12);
        rd("R2 alarm0 event", 4'd1, 32'h0001_0000);
        check("R2 irq", 64'(irq), 64'd1);
        check("R2 single pulse", 64'(act_cnt0), 64'd1);

        // R3: no re-fire when time revisits the alarm value
        wr(4'd1, 32'h0001_0000);
        tick(); cur_time = tgt;
        ticks(3);
        rd("R3 no refire", 4'd1, 32'h0);

        // R3: low word alone does not arm alarm 1
        tgt = cur_time + 64'd40;
        wr(4'd5, tgt[31:0]);
        ticks(8);
        rd("R3 lo only", 4'd1, 32'h0);
        tgt = cur_time + 64'd40;
        wr(4'd5, tgt[31:0]);
        wr(4'd6, tgt[63:32]);
        ticks(8);
        rd("R3 armed alarm1", 4'd1, 32'h0002_0000);

        // R7: zero write keeps, one write clears
        wr(4'd1, 32'h0);
        rd("R7 zero write", 4'd1, 32'h0002_0000);
        wr(4'd1, 32'h0002_0000);
        rd("R7 one write", 4'd1, 32'h0);

        // R4: polarity bits invert idle level
        wr(4'd0, 32'hC000_0000);
        ticks(1);
        check("R4 idle high", 64'(alarm_pin), 64'd3);
        rd("R9 ctrl", 4'd0, 32'hC000_0000);
        act_cnt0 = 0;
        tgt = cur_time + 64'd48;
        wr(4'd3, tgt[31:0]);
        wr(4'd4, tgt[63:32]);
        ticks(8);
        check("R4 low pulse count", 64'(act_cnt0), 64'd1);
        wr(4'd1, 32'h0001_0000);

        // R5: rising edge capture on trigger 0
        tick(); trig_in[0] = 1'b1; tk = cur_time;
        ticks(5);
        rd("R5 cap0 lo", 4'd8, tk[31:0] + 32'd16);
        rd("R6 cap0 hi", 4'd7, 32'(tk >> 32));
        rd("R5 trig0 event", 4'd1, 32'h0100_0000);

        // R5: falling select on trigger 1, rising ignored
        wr(4'd0, 32'hC000_0200);
        tick(); trig_in[1] = 1'b1;
        ticks(5);
        rd("R5 rise ignored", 4'd1, 32'h0100_0000);
        tick(); trig_in[1] = 1'b0; tk = cur_time;
        ticks(5);
        rd("R5 cap1 falling", 4'd10, tk[31:0] + 32'd16);
        rd("R5 trig1 event", 4'd1, 32'h0300_0000);

        // R6: overwrite while pending
        tick(); trig_in[0] = 1'b0;
        ticks(4);
        tick(); trig_in[0] = 1'b1; tk = cur_time;
        ticks(5);
        rd("R6 overwrite", 4'd8, tk[31:0] + 32'd16);

        // R8: masking gates the interrupt
        wr(4'd2, 32'h0);
        ticks(1);
        check("R8 masked irq", 64'(irq), 64'd0);
        wr(4'd2, 32'h0200_0000);
        ticks(1);
        check("R8 one mask bit", 64'(irq), 64'd1);
        wr(4'd1, 32'h0300_0000);
        ticks(1);
        check("R8 cleared irq", 64'(irq), 64'd0);

        // R7: a new event wins over a same-edge clear
        tgt = cur_time + 64'd24;
        wr(4'd3, tgt[31:0]);
        wr(4'd4, tgt[63:32]);
        wr(4'd1, 32'h0001_0000);
        rd("R7 set beats clear", 4'd1, 32'h0001_0000);

        ticks(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule